// File: doc/BRIEF.md
# Parallel Video Input Front-End

This block sits behind a parallel video port that delivers one pixel per pixel clock: a 30-bit data word made of three 10-bit colour channels, a vertical sync, a horizontal sync and a data-enable strobe. It makes the syncs active-high whatever their polarity on the wire. It routes each of the three input channels to an output lane through a programmable one-to-one map, which lets the board traces follow the easiest path. It also widens 6-bit or 8-bit components to 10 bits by copying their top bits into the unused low bits, so full scale is 0x3FF.

A watchdog times the gap between rising edges of the normalized vertical sync. If no edge arrives within a programmed number of pixel clocks, the block stops passing live video. It then drives its own eight-bar colour pattern, with timing from internal line and pixel counters, and raises a status flag. Live video returns only after two vertical-sync edges in a row, with no timeout between them. The switch happens on the second edge, which is a frame boundary. After reset the block starts in the pattern state.

Configuration is loaded with a single write strobe that carries every field. A channel map that is not a permutation is refused: the old map stays in use and an error flag is set until the next accepted map.

Top module: `pvid_front`

## Requirements
- R1: While reset is held, out_vsync, out_hsync, out_de and all three output components are 0, out_fallback is 1 and cfg_err is 0. Reset loads active-high syncs, 10-bit depth, the identity map and a timeout of four times FRAME_CYC.
- R2: cfg_vs_low=1 makes a low in_vsync the active level, and cfg_hs_low does the same for in_hsync. The outputs are always active-high and appear one pixel clock after the input is sampled.
- R3: in_data packs channel A in bits 9:0, channel B in bits 19:10 and channel C in bits 29:20. cfg_map holds one 2-bit selector per output lane: bits 1:0 for lane 0 (out_c0), bits 3:2 for lane 1 and bits 5:4 for lane 2. Code 0 selects A, 1 selects B and 2 selects C. Each lane carries the full selected channel.
- R4: A configuration write whose map uses code 3 or names one input twice leaves the active map unchanged and sets cfg_err. A later write with a valid map installs that map and clears cfg_err. The other fields of a write are always taken.
- R5: cfg_depth code 0 passes the 10 bits through. Code 1 keeps bits 9:2 and refills bits 1:0 with bits 9:8. Code 2 keeps bits 9:4 and refills bits 3:0 with bits 9:6. Code 3 acts like code 0. The discarded low input bits never affect the output.
- R6: If cfg_timeout pixel clocks pass with no rising edge of the normalized vertical sync, out_fallback goes to 1. While edges keep arriving closer together than that, out_fallback stays 0.
- R7: While out_fallback is 1, the outputs carry the internal pattern and the live inputs have no effect. Each active line shows eight bars of H_ACT/8 pixels. Bar i has colour index 7-i, and bits 2, 1 and 0 of that index set out_c0, out_c1 and out_c2 to 0x3FF (bit 1) or 0 (bit 0). The first bar is white and the last is black.
- R8: In the pattern state, a first vertical-sync edge keeps out_fallback at 1. A second edge before any timeout returns the block to live video, and out_fallback and the live data change together two clocks after that edge was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_vs_low | input | 1 | Vertical sync is active-low on the wire |
| cfg_hs_low | input | 1 | Horizontal sync is active-low on the wire |
| cfg_depth | input | 2 | Component depth code |
| cfg_map | input | 6 | Channel selector per output lane |
| cfg_timeout | input | TO_W | Sync-loss timeout in pixel clocks |
| in_vsync | input | 1 | Vertical sync from the port |
| in_hsync | input | 1 | Horizontal sync from the port |
| in_de | input | 1 | Data enable from the port |
| in_data | input | 30 | Three 10-bit channels A, B, C |
| out_vsync | output | 1 | Active-high vertical sync |
| out_hsync | output | 1 | Active-high horizontal sync |
| out_de | output | 1 | Pixel valid |
| out_c0 | output | 10 | Output lane 0 component |
| out_c1 | output | 10 | Output lane 1 component |
| out_c2 | output | 10 | Output lane 2 component |
| out_fallback | output | 1 | Pattern substituted for live video |
| cfg_err | output | 1 | Last map write was refused |

## Verification
The assertions assume the configuration write is a single-cycle strobe whose fields are stable in that cycle. They also assume that any vertical-sync edge the bench produces is an intended frame start, so that every exit from the pattern can be traced back to a sampled edge. The stimulus writes configuration only at falling clock edges. It spaces its sync pulses well inside the programmed timeout whenever live video is under test. It drops the pulses altogether only when loss is the point, so that no check lands near the exact timeout boundary.

// File: rtl/pvid_pkg.sv
package pvid_pkg;

    localparam int CW  = 10;
    localparam int NCH = 3;
    localparam int BW  = CW * NCH;

    typedef logic [CW-1:0]         comp_t;
    typedef logic [1:0]            sel_t;
    typedef logic [NCH-1:0][1:0]   map_t;

    typedef enum logic [1:0] {
        DEPTH_10  = 2'd0,
        DEPTH_8   = 2'd1,
        DEPTH_6   = 2'd2,
        DEPTH_RSV = 2'd3
    } depth_e;

    typedef struct packed {
        logic                   vs;
        logic                   hs;
        logic                   de;
        logic [NCH-1:0][CW-1:0] c;
    } pix_t;

    // a map is legal when every lane names a real channel and no channel twice
    function automatic logic map_ok(map_t m);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (m[i] == 2'd3) ok = 1'b0;
            for (int j = i + 1; j < NCH; j++)
                if (m[i] == m[j]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic comp_t pick(logic [BW-1:0] bus, sel_t s);
        case (s)
            2'd0:    return bus[CW-1:0];
            2'd1:    return bus[2*CW-1:CW];
            2'd2:    return bus[3*CW-1:2*CW];
            default: return '0;
        endcase
    endfunction

    // MSB-justified component widened by copying its top bits downward
    function automatic comp_t expand(comp_t x, depth_e d);
        case (d)
            DEPTH_8: return {x[9:2], x[9:8]};
            DEPTH_6: return {x[9:4], x[9:6]};
            default: return x;
        endcase
    endfunction

endpackage

// File: rtl/pvid_cfg.sv
module pvid_cfg
    import pvid_pkg::*;
#(
    parameter int TO_W   = 16,
    parameter int DEF_TO = 4000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            vinv_i,
    input  logic            hinv_i,
    input  logic [1:0]      depth_i,
    input  map_t            map_i,
    input  logic [TO_W-1:0] to_i,
    output logic            vinv,
    output logic            hinv,
    output depth_e          depth,
    output map_t            map,
    output logic [TO_W-1:0] timeout,
    output logic            err
);

    localparam map_t MAP_IDENT = {2'd2, 2'd1, 2'd0};

    always_ff @(posedge clk) begin
        if (rst) begin
            vinv    <= 1'b0;
            hinv    <= 1'b0;
            depth   <= DEPTH_10;
            map     <= MAP_IDENT;
            timeout <= TO_W'(DEF_TO);
            err     <= 1'b0;
        end else if (we) begin
            vinv    <= vinv_i;
            hinv    <= hinv_i;
            depth   <= depth_e'(depth_i);
            timeout <= to_i;
            if (map_ok(map_i)) begin
                map <= map_i;
                err <= 1'b0;
            end else begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pvid_sync_wd.sv
module pvid_sync_wd #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vs_edge,
    input  logic [TO_W-1:0] timeout,
    output logic            fallback
);

    logic [TO_W-1:0] cnt;
    logic            armed;   // one edge seen with no timeout since
    logic [TO_W:0]   nxt;

    assign nxt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b0;
            fallback <= 1'b1;
        end else if (vs_edge) begin
            cnt   <= '0;
            armed <= 1'b1;
            if (fallback && armed)
                fallback <= 1'b0;
        end else if (nxt >= {1'b0, timeout}) begin
            armed    <= 1'b0;
            fallback <= 1'b1;
        end else begin
            cnt <= nxt[TO_W-1:0];
        end
    end

endmodule

// File: rtl/pvid_bars.sv
module pvid_bars
    import pvid_pkg::*;
#(
    parameter int H_ACT = 48,
    parameter int H_TOT = 64,
    parameter int V_ACT = 12,
    parameter int V_TOT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output pix_t pat
);

    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);
    localparam int BAR_W = H_ACT / 8;

    logic [HW-1:0] h;
    logic [VW-1:0] v;
    logic [HW-1:0] bar;
    logic [2:0]    idx;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            h <= '0;
            v <= '0;
        end else if (h == HW'(H_TOT - 1)) begin
            h <= '0;
            v <= (v == VW'(V_TOT - 1)) ? '0 : v + 1'b1;
        end else begin
            h <= h + 1'b1;
        end
    end

    always_comb begin
        bar    = h / HW'(BAR_W);
        idx    = 3'd7 - bar[2:0];
        pat.de = (h < HW'(H_ACT)) && (v < VW'(V_ACT));
        pat.hs = (h >= HW'(H_ACT + 2)) && (h < HW'(H_ACT + 6));
        pat.vs = (v >= VW'(V_ACT + 1)) && (v < VW'(V_ACT + 3));
        for (int k = 0; k < NCH; k++)
            pat.c[k] = (pat.de && idx[NCH-1-k]) ? comp_t'(10'h3FF) : '0;
    end

endmodule

// File: rtl/pvid_front.sv
module pvid_front
    import pvid_pkg::*;
#(
    parameter int TO_W      = 16,
    parameter int FRAME_CYC = 1000,
    parameter int H_ACT     = 48,
    parameter int H_TOT     = 64,
    parameter int V_ACT     = 12,
    parameter int V_TOT     = 20
) (
    input  logic            pclk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic            cfg_vs_low,
    input  logic            cfg_hs_low,
    input  logic [1:0]      cfg_depth,
    input  logic [5:0]      cfg_map,
    input  logic [TO_W-1:0] cfg_timeout,
    input  logic            in_vsync,
    input  logic            in_hsync,
    input  logic            in_de,
    input  logic [29:0]     in_data,
    output logic            out_vsync,
    output logic            out_hsync,
    output logic            out_de,
    output logic [9:0]      out_c0,
    output logic [9:0]      out_c1,
    output logic [9:0]      out_c2,
    output logic            out_fallback,
    output logic            cfg_err
);

    localparam int DEF_TO = 4 * FRAME_CYC;

    logic            vinv_q, hinv_q;
    depth_e          depth_q;
    map_t            map_q;
    logic [TO_W-1:0] timeout_q;
    logic            vs_norm, vs_prev, vs_edge;
    logic            fb;
    pix_t            live, pat, out_q;
    logic            out_fb_q;

    pvid_cfg #(.TO_W(TO_W), .DEF_TO(DEF_TO)) u_cfg (
        .clk     (pclk),
        .rst     (rst),
        .we      (cfg_we),
        .vinv_i  (cfg_vs_low),
        .hinv_i  (cfg_hs_low),
        .depth_i (cfg_depth),
        .map_i   (map_t'(cfg_map)),
        .to_i    (cfg_timeout),
        .vinv    (vinv_q),
        .hinv    (hinv_q),
        .depth   (depth_q),
        .map     (map_q),
        .timeout (timeout_q),
        .err     (cfg_err)
    );

    assign vs_norm = in_vsync ^ vinv_q;
    assign vs_edge = vs_norm & ~vs_prev;

    always_ff @(posedge pclk) begin
        if (rst) vs_prev <= 1'b0;
        else     vs_prev <= vs_norm;
    end

    pvid_sync_wd #(.TO_W(TO_W)) u_wd (
        .clk      (pclk),
        .rst      (rst),
        .vs_edge  (vs_edge),
        .timeout  (timeout_q),
        .fallback (fb)
    );

    pvid_bars #(.H_ACT(H_ACT), .H_TOT(H_TOT), .V_ACT(V_ACT), .V_TOT(V_TOT)) u_bars (
        .clk (pclk),
        .rst (rst),
        .run (fb),
        .pat (pat)
    );

    assign live.vs = vs_norm;
    assign live.hs = in_hsync ^ hinv_q;
    assign live.de = in_de;

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        assign live.c[k] = expand(pick(in_data, map_q[k]), depth_q);
    end

    always_ff @(posedge pclk) begin
        if (rst) begin
            out_q    <= '0;
            out_fb_q <= 1'b1;
        end else begin
            out_q    <= fb ? pat : live;
            out_fb_q <= fb;
        end
    end

    assign out_vsync    = out_q.vs;
    assign out_hsync    = out_q.hs;
    assign out_de       = out_q.de;
    assign out_c0       = out_q.c[0];
    assign out_c1       = out_q.c[1];
    assign out_c2       = out_q.c[2];
    assign out_fallback = out_fb_q;

endmodule

// File: rtl/pvid_front_chk.sv
module pvid_front_chk
    import pvid_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [5:0] cfg_map,
    input map_t       map_q,
    input logic       cfg_err,
    input logic       vs_edge,
    input logic       out_fallback,
    input logic       out_de,
    input logic [9:0] out_c0,
    input logic [9:0] out_c1,
    input logic [9:0] out_c2
);

    logic bad_wr;
    assign bad_wr = cfg_we && !map_ok(map_t'(cfg_map));

    AST_BAD_MAP_KEPT: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> $stable(map_q)); // R4

    AST_BAD_MAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> cfg_err); // R4

    AST_LOSS_NEEDS_SILENCE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_fallback) |-> !$past(vs_edge, 2)); // R6

    AST_PATTERN_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (out_fallback && out_de) |->
            ((out_c0 == 10'h000 || out_c0 == 10'h3FF) &&
             (out_c1 == 10'h000 || out_c1 == 10'h3FF) &&
             (out_c2 == 10'h000 || out_c2 == 10'h3FF))); // R7

    AST_EXIT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(out_fallback) |-> $past(vs_edge, 2)); // R8

endmodule

bind pvid_front pvid_front_chk u_chk (
    .clk          (pclk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_map      (cfg_map),
    .map_q        (map_q),
    .cfg_err      (cfg_err),
    .vs_edge      (vs_edge),
    .out_fallback (out_fallback),
    .out_de       (out_de),
    .out_c0       (out_c0),
    .out_c1       (out_c1),
    .out_c2       (out_c2)
);

// File: tb/sim_pvid_front.sv
`timescale 1ns/1ps
module sim_pvid_front;

    localparam int TO_W  = 16;
    localparam int H_ACT = 48;
    localparam int BAR_W = H_ACT / 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            cfg_we;
    logic            cfg_vs_low, cfg_hs_low;
    logic [1:0]      cfg_depth;
    logic [5:0]      cfg_map;
    logic [TO_W-1:0] cfg_timeout;
    logic            in_vsync, in_hsync, in_de;
    logic [29:0]     in_data;
    logic            out_vsync, out_hsync, out_de;
    logic [9:0]      out_c0, out_c1, out_c2;
    logic            out_fallback, cfg_err;

    int checks = 0;
    int errors = 0;

    // bench copy of the settings it last wrote
    logic            sh_vlow = 1'b0, sh_hlow = 1'b0;
    logic [1:0]      sh_depth = 2'd0;
    logic [5:0]      sh_map = 6'b10_01_00;
    logic [TO_W-1:0] sh_to = 16'd100;

    always #5 clk = ~clk;

    pvid_front u0 (
        .pclk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_vs_low(cfg_vs_low),
        .cfg_hs_low(cfg_hs_low), .cfg_depth(cfg_depth), .cfg_map(cfg_map),
        .cfg_timeout(cfg_timeout), .in_vsync(in_vsync), .in_hsync(in_hsync),
        .in_de(in_de), .in_data(in_data), .out_vsync(out_vsync),
        .out_hsync(out_hsync), .out_de(out_de), .out_c0(out_c0),
        .out_c1(out_c1), .out_c2(out_c2), .out_fallback(out_fallback),
        .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_lines();
        in_vsync = sh_vlow;
        in_hsync = sh_hlow;
    endtask

    task automatic cfg_write(input logic [5:0] map);
        @(negedge clk);
        cfg_we = 1'b1; cfg_vs_low = sh_vlow; cfg_hs_low = sh_hlow;
        cfg_depth = sh_depth; cfg_map = map; cfg_timeout = sh_to;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic vpulse();
        @(negedge clk); in_vsync = ~sh_vlow;
        @(negedge clk);
        @(negedge clk); in_vsync = sh_vlow;
    endtask

    task automatic pix(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c);
        @(negedge clk);
        in_de = 1'b1; in_data = {c, b, a};
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 vsync", out_vsync, 0);
        chk("R1 hsync", out_hsync, 0);
        chk("R1 de", out_de, 0);
        chk("R1 comps", {out_c0, out_c1, out_c2}, 0);
        chk("R1 fallback", out_fallback, 1);
        chk("R1 err", cfg_err, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_resync();
        cfg_write(sh_map);
        vpulse();
        repeat (20) @(negedge clk);
        chk("R8 one edge keeps pattern", out_fallback, 1);
        vpulse();
        repeat (3) @(negedge clk);
        chk("R8 second edge returns live", out_fallback, 0);
        pix(10'h123, 10'h000, 10'h000);
        chk("R8 live data", out_c0, 10'h123);
    endtask

    task automatic t_remap();
        vpulse();
        pix(10'h111, 10'h222, 10'h333);
        chk("R3 identity", {out_c0, out_c1, out_c2}, {10'h111, 10'h222, 10'h333});
        chk("R6 stays live with pulses", out_fallback, 0);
        sh_map = 6'b01_00_10;          // lane0<-C lane1<-A lane2<-B
        cfg_write(sh_map);
        pix(10'h111, 10'h222, 10'h333);
        chk("R3 rotated", {out_c0, out_c1, out_c2}, {10'h333, 10'h111, 10'h222});
    endtask

    task automatic t_bad_map();
        vpulse();
        cfg_write(6'b01_00_00);        // A twice
        chk("R4 err on duplicate", cfg_err, 1);
        pix(10'h111, 10'h222, 10'h333);
        chk("R4 old map kept", {out_c0, out_c1, out_c2}, {10'h333, 10'h111, 10'h222});
        cfg_write(6'b11_01_00);        // code 3
        chk("R4 err on code 3", cfg_err, 1);
        sh_map = 6'b00_01_10;          // lane0<-C lane1<-B lane2<-A
        cfg_write(sh_map);
        chk("R4 err cleared", cfg_err, 0);
        pix(10'h111, 10'h222, 10'h333);
        chk("R4 new map used", {out_c0, out_c1, out_c2}, {10'h333, 10'h222, 10'h111});
        sh_map = 6'b10_01_00;
        cfg_write(sh_map);
    endtask

    task automatic t_depth();
        vpulse();
        sh_depth = 2'd1; cfg_write(sh_map);
        pix(10'h2A5, 10'h3FC, 10'h000);
        chk("R5 8-bit widen", out_c0, 10'h2A6);
        chk("R5 8-bit full scale", out_c1, 10'h3FF);
        sh_depth = 2'd2; cfg_write(sh_map);
        pix(10'h2A5, 10'h3F3, 10'h000);
        chk("R5 6-bit widen", out_c0, 10'h2AA);
        chk("R5 6-bit low bits ignored", out_c1, 10'h3FF);
        vpulse();
        sh_depth = 2'd3; cfg_write(sh_map);
        pix(10'h2A5, 10'h000, 10'h000);
        chk("R5 code 3 passes", out_c0, 10'h2A5);
        sh_depth = 2'd0; cfg_write(sh_map);
        pix(10'h2A5, 10'h000, 10'h000);
        chk("R5 10-bit passes", out_c0, 10'h2A5);
    endtask

    task automatic t_polarity();
        vpulse();
        @(negedge clk); in_hsync = 1'b1;
        @(negedge clk);
        chk("R2 high hsync active-high", out_hsync, 1);
        sh_vlow = 1'b1; sh_hlow = 1'b1;
        cfg_write(sh_map);
        idle_lines();
        vpulse();
        @(negedge clk); in_hsync = 1'b0;
        @(negedge clk);
        chk("R2 low hsync normalized", out_hsync, 1);
        @(negedge clk); in_hsync = 1'b1;
        @(negedge clk);
        chk("R2 idle hsync normalized", out_hsync, 0);
        @(negedge clk); in_vsync = 1'b0;
        @(negedge clk);
        chk("R2 low vsync normalized", out_vsync, 1);
        in_vsync = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 idle vsync normalized", out_vsync, 0);
        chk("R6 live after polarity change", out_fallback, 0);
        sh_vlow = 1'b0; sh_hlow = 1'b0;
        cfg_write(sh_map);
        idle_lines();
        vpulse();
    endtask

    task automatic t_loss_and_pattern();
        int n;
        in_de = 1'b1; in_data = {10'h155, 10'h0AA, 10'h155};
        repeat (150) @(negedge clk);
        chk("R6 fallback after silence", out_fallback, 1);
        n = 0;
        while (out_de && n < 3000) begin @(negedge clk); n++; end
        while (!out_de && n < 3000) begin @(negedge clk); n++; end
        chk("R7 pattern line found", out_de, 1);
        for (int i = 0; i < H_ACT; i++) begin
            logic [2:0] idx;
            idx = 3'(7 - i / BAR_W);
            chk("R7 bar colour", {out_c0, out_c1, out_c2},
                {idx[2] ? 10'h3FF : 10'h000, idx[1] ? 10'h3FF : 10'h000,
                 idx[0] ? 10'h3FF : 10'h000});
            @(negedge clk);
        end
        chk("R7 blanking after line", out_de, 0);
    endtask

    task automatic t_return();
        vpulse();
        repeat (30) @(negedge clk);
        chk("R8 single edge not enough", out_fallback, 1);
        vpulse();
        repeat (3) @(negedge clk);
        chk("R8 back to live", out_fallback, 0);
        pix(10'h0F0, 10'h00F, 10'h3C3);
        chk("R8 live lanes", {out_c0, out_c1, out_c2}, {10'h0F0, 10'h00F, 10'h3C3});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cfg_we = 1'b0; cfg_vs_low = 1'b0; cfg_hs_low = 1'b0; cfg_depth = 2'd0;
        cfg_map = 6'b10_01_00; cfg_timeout = 16'd100;
        in_vsync = 1'b0; in_hsync = 1'b0; in_de = 1'b0; in_data = '0;
        t_reset();
        t_resync();
        t_remap();
        t_bad_map();
        t_depth();
        t_polarity();
        t_loss_and_pattern();
        t_return();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule